// File: doc/BRIEF.md
# Stack and Bus Fault Capture

This unit sits beside a simple processor core and turns two kinds of fault into a single exception request. The first kind is a stack-relative access whose address falls outside a window set by a lower and an upper limit register. The second kind is an error response from the instruction port or the data port. A fault that qualifies stores two things: the address that caused it goes into a fault-address register, and a 5-bit cause code goes into a fault-cause register. It also raises a request to the core for one cycle.

Stack window violations always trap. Bus errors trap only when the global exception enable is set and the trap option for that port is also on. When no fault qualifies, the capture registers keep their values. Software sets the two limits through a small write port. The core's exception sequencer reads the captured address and cause.

Top module: `stack_bus_fault_capture`

## Requirements
- R1: After reset, exc_req is 0, fault_addr is 0 and fault_cause is 0. The lower limit is 0 and the upper limit is all ones, so no stack access violates.
- R2: When lim_we is 1, lim_wdata is written to the lower limit if lim_sel is 0 and to the upper limit if lim_sel is 1. The new value applies to stack accesses from the next cycle on. An access in the same cycle as the write is checked against the old value.
- R3: A stack access (stk_valid=1) violates when stk_addr is below the lower limit or above the upper limit. An address equal to either limit is inside the window.
- R4: One cycle after a violating stack access, exc_req is 1, fault_cause is 0x07 and fault_addr equals stk_addr. This happens whatever exc_en is.
- R5: When exc_en is 0, ibus_err and dbus_err have no effect on exc_req, fault_addr or fault_cause.
- R6: An ibus_err with exc_en=1 and ibus_trap_en=1 gives, one cycle later, exc_req=1, fault_cause=0x03 and fault_addr=ibus_addr. With ibus_trap_en=0, ibus_err is ignored.
- R7: A dbus_err with exc_en=1 and dbus_trap_en=1 gives, one cycle later, exc_req=1, fault_cause=0x04 and fault_addr=dbus_addr. With dbus_trap_en=0, dbus_err is ignored.
- R8: When faults qualify in the same cycle, the stack violation wins over the instruction-bus error, and the instruction-bus error wins over the data-bus error.
- R9: exc_req is 1 only in the cycle after a cycle with a qualifying fault. In a cycle that follows a cycle with no qualifying fault, fault_addr and fault_cause keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lim_we | input | 1 | Limit register write strobe |
| lim_sel | input | 1 | 0 selects the lower limit, 1 the upper limit |
| lim_wdata | input | AW | Limit write data |
| stk_valid | input | 1 | A stack-relative access is present |
| stk_addr | input | AW | Address of the stack access |
| ibus_err | input | 1 | Instruction port error response |
| ibus_addr | input | AW | Address of the failed fetch |
| dbus_err | input | 1 | Data port error response (load or store) |
| dbus_addr | input | AW | Address of the failed data access |
| exc_en | input | 1 | Global exception enable |
| ibus_trap_en | input | 1 | Instruction-bus error trap option |
| dbus_trap_en | input | 1 | Data-bus error trap option |
| exc_req | output | 1 | Exception request, one cycle per fault |
| fault_addr | output | AW | Captured faulting address |
| fault_cause | output | CW | Captured cause code |

## Verification
The bench drives stack addresses exactly at each limit and one step past it. A design that used a strict or a wrong-sided compare would trap at the limit, or would miss the first address outside it. The bench also writes a limit and makes a stack access in the same cycle. A design that forwarded the new limit would judge that access against the wrong value. It raises a stack violation and both bus errors together, and it raises bus errors with the global enable clear. Wrong priority shows up as the wrong cause and address, and gating stack faults by the enable shows up as a missing request. Quiet cycles after a fault catch capture registers that clear instead of holding.

// File: rtl/stack_bus_fault_capture.sv
module stack_bus_fault_capture #(
  parameter int AW = 32,
  parameter int CW = 5,
  parameter logic [CW-1:0] CAUSE_STACK = 5'h07,
  parameter logic [CW-1:0] CAUSE_IBUS  = 5'h03,
  parameter logic [CW-1:0] CAUSE_DBUS  = 5'h04
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lim_we,
  input  logic          lim_sel,
  input  logic [AW-1:0] lim_wdata,
  input  logic          stk_valid,
  input  logic [AW-1:0] stk_addr,
  input  logic          ibus_err,
  input  logic [AW-1:0] ibus_addr,
  input  logic          dbus_err,
  input  logic [AW-1:0] dbus_addr,
  input  logic          exc_en,
  input  logic          ibus_trap_en,
  input  logic          dbus_trap_en,
  output logic          exc_req,
  output logic [AW-1:0] fault_addr,
  output logic [CW-1:0] fault_cause
);

  logic [AW-1:0] lim_lo_q, lim_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_lo_q <= '0;
      lim_hi_q <= '1;
    end else if (lim_we) begin
      if (lim_sel) lim_hi_q <= lim_wdata;
      else         lim_lo_q <= lim_wdata;
    end
  end

  wire stk_hit  = stk_valid && (stk_addr < lim_lo_q || stk_addr > lim_hi_q);
  wire ibus_hit = ibus_err && exc_en && ibus_trap_en;
  wire dbus_hit = dbus_err && exc_en && dbus_trap_en;
  wire any_hit  = stk_hit || ibus_hit || dbus_hit;

  logic [AW-1:0] sel_addr;
  logic [CW-1:0] sel_cause;

  always_comb begin
    if (stk_hit) begin
      sel_addr  = stk_addr;
      sel_cause = CAUSE_STACK;
    end else if (ibus_hit) begin
      sel_addr  = ibus_addr;
      sel_cause = CAUSE_IBUS;
    end else begin
      sel_addr  = dbus_addr;
      sel_cause = CAUSE_DBUS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req     <= 1'b0;
      fault_addr  <= '0;
      fault_cause <= '0;
    end else begin
      exc_req <= any_hit;
      if (any_hit) begin
        fault_addr  <= sel_addr;
        fault_cause <= sel_cause;
      end
    end
  end

endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk #(
  parameter int AW = 32,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] lo,
  input logic [AW-1:0] hi,
  input logic          stk_valid,
  input logic [AW-1:0] stk_addr,
  input logic          ibus_err,
  input logic [AW-1:0] ibus_addr,
  input logic          dbus_err,
  input logic          exc_en,
  input logic          ibus_trap_en,
  input logic          exc_req,
  input logic [AW-1:0] fault_addr,
  input logic [CW-1:0] fault_cause
);

  wire viol = stk_valid && (stk_addr < lo || stk_addr > hi);

  p_stack_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> exc_req && fault_cause == 5'h07 && fault_addr == $past(stk_addr));

  p_bus_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_en && !viol) |=> !exc_req);

  p_ibus_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!viol && ibus_err && exc_en && ibus_trap_en)
      |=> exc_req && fault_cause == 5'h03 && fault_addr == $past(ibus_addr));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_req |-> $stable(fault_addr) && $stable(fault_cause));

  p_cause_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (fault_cause == 5'h07 || fault_cause == 5'h03 || fault_cause == 5'h04));

  p_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid && stk_addr >= lo && stk_addr <= hi && !ibus_err && !dbus_err) |=> !exc_req);

endmodule

bind stack_bus_fault_capture fault_capture_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo(lim_lo_q), .hi(lim_hi_q),
  .stk_valid(stk_valid), .stk_addr(stk_addr),
  .ibus_err(ibus_err), .ibus_addr(ibus_addr), .dbus_err(dbus_err),
  .exc_en(exc_en), .ibus_trap_en(ibus_trap_en),
  .exc_req(exc_req), .fault_addr(fault_addr), .fault_cause(fault_cause)
);

// File: tb/test_stack_bus_fault_capture.sv
module test_stack_bus_fault_capture;
  localparam int AW = 32;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0;
  logic lim_we = 0, lim_sel = 0;
  logic [AW-1:0] lim_wdata = '0;
  logic stk_valid = 0, ibus_err = 0, dbus_err = 0;
  logic [AW-1:0] stk_addr = '0, ibus_addr = '0, dbus_addr = '0;
  logic exc_en = 0, ibus_trap_en = 0, dbus_trap_en = 0;
  logic exc_req;
  logic [AW-1:0] fault_addr;
  logic [CW-1:0] fault_cause;

  int checks = 0, errors = 0;
  logic [AW-1:0] m_lo = '0, m_hi = '1, e_addr = '0;
  logic [CW-1:0] e_cause = '0;
  bit done = 0;

  always #10 clk = ~clk;

  stack_bus_fault_capture i_stack_bus_fault_capture (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_sel(lim_sel), .lim_wdata(lim_wdata),
    .stk_valid(stk_valid), .stk_addr(stk_addr), .ibus_err(ibus_err), .ibus_addr(ibus_addr),
    .dbus_err(dbus_err), .dbus_addr(dbus_addr), .exc_en(exc_en),
    .ibus_trap_en(ibus_trap_en), .dbus_trap_en(dbus_trap_en),
    .exc_req(exc_req), .fault_addr(fault_addr), .fault_cause(fault_cause));

  function automatic string pick_tag(bit v, bit i, bit d);
    if (v) return "R4";
    if ((ibus_err || dbus_err) && !exc_en) return "R5";
    if (i) return "R6";
    if (d) return "R7";
    return "R9";
  endfunction

  task automatic step(input bit we, input bit sel, input logic [AW-1:0] wd,
                      input bit sv, input logic [AW-1:0] sa,
                      input bit ie, input logic [AW-1:0] ia,
                      input bit de, input logic [AW-1:0] da,
                      input bit en, input bit ien, input bit den, input string tag);
    bit v, i, d, e_req;
    string t;
    lim_we = we; lim_sel = sel; lim_wdata = wd;
    stk_valid = sv; stk_addr = sa; ibus_err = ie; ibus_addr = ia;
    dbus_err = de; dbus_addr = da; exc_en = en; ibus_trap_en = ien; dbus_trap_en = den;
    v = sv && (sa < m_lo || sa > m_hi);
    i = ie && en && ien;
    d = de && en && den;
    e_req = v || i || d;
    if (v)      begin e_addr = sa; e_cause = 5'h07; end
    else if (i) begin e_addr = ia; e_cause = 5'h03; end
    else if (d) begin e_addr = da; e_cause = 5'h04; end
    if (we) begin if (sel) m_hi = wd; else m_lo = wd; end
    t = (tag == "") ? pick_tag(v, i, d) : tag;
    @(negedge clk);
    checks++;
    if (exc_req !== e_req || fault_addr !== e_addr || fault_cause !== e_cause) begin
      errors++;
      $display("FAIL %s: req/addr/cause actual %0b/%h/%h expected %0b/%h/%h",
               t, exc_req, fault_addr, fault_cause, e_req, e_addr, e_cause);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    checks++;
    if (exc_req !== 0 || fault_addr !== 0 || fault_cause !== 0) begin
      errors++;
      $display("FAIL R1: actual %0b/%h/%h expected 0/0/0", exc_req, fault_addr, fault_cause);
    end
    rst_n = 1;
    @(negedge clk);
    // R1: default window admits everything
    step(0,0,0, 1,32'h0, 0,0, 0,0, 0,0,0, "R1");
    step(0,0,0, 1,32'hFFFF_FFFF, 0,0, 0,0, 0,0,0, "R1");
    // R2: write limits; same-cycle access judged against old limit
    step(1,0,32'h1000, 1,32'h0800, 0,0, 0,0, 0,0,0, "R2");
    step(1,1,32'h2000, 1,32'h0800, 0,0, 0,0, 0,0,0, "R2");
    step(0,0,0, 1,32'h2001, 0,0, 0,0, 0,0,0, "R2");
    // R3: boundaries
    step(0,0,0, 1,32'h1000, 0,0, 0,0, 1,0,0, "R3");
    step(0,0,0, 1,32'h2000, 0,0, 0,0, 1,0,0, "R3");
    step(0,0,0, 1,32'h0FFF, 0,0, 0,0, 1,0,0, "R3");
    step(0,0,0, 1,32'h2001, 0,0, 0,0, 0,0,0, "R4");
    // R5: bus errors ignored with global enable clear
    step(0,0,0, 0,0, 1,32'hAAAA_0000, 1,32'hBBBB_0000, 0,1,1, "R5");
    // R6 / R7: options
    step(0,0,0, 0,0, 1,32'hAAAA_0004, 0,0, 1,0,1, "R6");
    step(0,0,0, 0,0, 1,32'hAAAA_0008, 0,0, 1,1,0, "R6");
    step(0,0,0, 0,0, 0,0, 1,32'hBBBB_0004, 1,1,0, "R7");
    step(0,0,0, 0,0, 0,0, 1,32'hBBBB_0008, 1,0,1, "R7");
    // R8: priority
    step(0,0,0, 1,32'h3000, 1,32'hAAAA_000C, 1,32'hBBBB_000C, 1,1,1, "R8");
    step(0,0,0, 1,32'h1800, 1,32'hAAAA_0010, 1,32'hBBBB_0010, 1,1,1, "R8");
    // R9: quiet cycles hold capture
    step(0,0,0, 0,0, 0,0, 0,0, 1,1,1, "R9");
    step(0,0,0, 1,32'h1800, 0,0, 0,0, 1,1,1, "R9");
    for (int n = 0; n < 2000; n++) begin
      bit we = ($urandom % 8) == 0;
      logic [AW-1:0] base = ($urandom % 2) ? m_lo : m_hi;
      logic [AW-1:0] sa = ($urandom % 2) ? base + AW'($urandom % 5) - AW'(2) : $urandom;
      step(we, 1'($urandom), $urandom % 32'h0001_0000 + (($urandom % 2) ? 32'h0 : 32'h8000),
           ($urandom % 3) == 0, sa, ($urandom % 4) == 0, $urandom,
           ($urandom % 4) == 0, $urandom, 1'($urandom), 1'($urandom), 1'($urandom), "");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule